// File: doc/BRIEF.md
# Transmit Holding Buffer with Interrupt Control

This block is the one-byte holding stage that sits in front of the transmit shift register of a serial channel. The CPU writes a byte into it. The shift register takes the byte when it asks for one. The block reports a buffer-empty status bit that software may poll at any time. It also keeps a transmit interrupt pending bit, which is set only on the edge of the buffer draining, or at the end of a synchronous frame once the closing flag or sync character is loaded after the CRC.

The pending bit is cleared by a data write or by an explicit clear command, so software can close a frame without supplying data. The interrupt request output is the pending bit gated by the master interrupt enable. The pending bit itself keeps updating when the master enable is off, so software can poll it. Two sticky error flags are provided. The first reports a write that arrived while the CRC bytes were being sent, which corrupts the CRC. The second reports a write made while the buffer was already full.

Top module: `txbuf_irq_ctrl`

## Requirements
- R1: One cycle after `rst_n` is low or `chan_rst` is high, `buf_empty`=1 and `irq_pend`=0, `late_wr`=0, `ovr_err`=0.
- R2: A `wr_stb` while `buf_empty`=1 stores `wr_data`. From the next cycle, `buf_empty`=0 and `ld_data` equals the written byte.
- R3: While the buffer is full and `ld_req`=1, `ld_valid`=1 in that same cycle and `ld_data` shows the held byte. `buf_empty` returns to 1 on the next cycle. When the buffer is empty, `ld_valid` stays 0.
- R4: With `tx_ie`=1, a full-to-empty transfer sets `irq_pend` on the next cycle. With `tx_ie`=0 the transfer does not set it. Raising `tx_ie` while the buffer is already empty does not set it.
- R5: A `crc_done` pulse with `tx_ie`=1 sets `irq_pend` and `buf_empty` on the next cycle. Any byte still held is dropped.
- R6: A `wr_stb` or an `irq_clr` pulse clears `irq_pend` on the next cycle. A set event in the same cycle takes priority over the clear.
- R7: `irq_req` = `irq_pend` AND `mie`. With `mie`=0, `irq_pend` still sets and can be read.
- R8: A `wr_stb` while `crc_busy`=1 sets the sticky `late_wr` flag on the next cycle. It stays set until a reset. A write with `crc_busy`=0 leaves it clear.
- R9: A `wr_stb` while the buffer is full is ignored: the held byte is unchanged. It also sets the sticky `ovr_err` flag, which is cleared only by a reset.
- R10: `buf_empty` follows the buffer state whatever the value of `tx_ie` or `mie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| wr_stb | input | 1 | CPU data write strobe |
| wr_data | input | DATA_W | CPU write data |
| irq_clr | input | 1 | Command that clears the transmit interrupt pending bit |
| tx_ie | input | 1 | Transmit interrupt enable |
| mie | input | 1 | Master interrupt enable |
| ld_req | input | 1 | Shift register asks for the next byte |
| crc_busy | input | 1 | CRC bytes are in the shift register |
| crc_done | input | 1 | Last CRC bit gone; flag or sync character loaded |
| ld_valid | output | 1 | Byte is handed to the shift register this cycle |
| ld_data | output | DATA_W | Held byte |
| buf_empty | output | 1 | Buffer-empty status |
| irq_pend | output | 1 | Transmit interrupt pending |
| irq_req | output | 1 | Interrupt request |
| late_wr | output | 1 | Sticky flag: a write landed during CRC transmission |
| ovr_err | output | 1 | Sticky flag: a write was made to a full buffer |

## Verification
The bench builds the block with `DATA_W`=4. This makes a full sweep practical: every data value passes through the buffer under all four combinations of `tx_ie` and `mie`. Each pass checks the byte presented at transfer, the empty edge, the pending bit and the gated request. Directed sequences then cover the edge-only nature of the pending bit, end-of-frame setting, the set-over-clear priority, and the sticky error flags with their reset behaviour.

// File: rtl/txbuf_pkg.sv
// Package: shared types for the transmit holding buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package txbuf_pkg;
    // Operation chosen for the pending bit in one cycle
    typedef enum logic [1:0] {
        PEND_KEEP  = 2'd0,
        PEND_SET   = 2'd1,
        PEND_CLEAR = 2'd2,
        PEND_RESET = 2'd3
    } pend_op_e;

    // Priority encoder for the pending bit: reset, then set, then clear
    function automatic pend_op_e pend_pick(input logic rst, input logic set, input logic clr);
        if (rst)      return PEND_RESET;
        else if (set) return PEND_SET;
        else if (clr) return PEND_CLEAR;
        else          return PEND_KEEP;
    endfunction
endpackage

// File: rtl/txbuf_hold.sv
// Module: txbuf_hold
// Holds one byte for the shift register, tracks the full state and the
// sticky write-to-full error.
// Assumes: write accepted only when empty; transfer happens when ld_req and full.
module txbuf_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_req,
    input  logic              crc_done,
    output logic              full,
    output logic              xfer,
    output logic [DATA_W-1:0] data,
    output logic              ovr_err
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;
    logic              accept;

    // Decode this cycle's accept and transfer events
    always_comb begin
        accept = wr_stb && !full_q;
        xfer   = ld_req && full_q;
    end

    // Full flag: write fills, transfer or end of frame empties
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)      full_q <= 1'b0;
        else if (accept)             full_q <= 1'b1;
        else if (xfer || crc_done)   full_q <= 1'b0;
    end

    // Data register: captured only on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= wr_data;
    end

    // Sticky error for a write made to a full buffer
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)     ovr_q <= 1'b0;
        else if (wr_stb && full_q)  ovr_q <= 1'b1;
    end

    assign full    = full_q;
    assign data    = data_q;
    assign ovr_err = ovr_q;

    // R3
    xfer_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && full_q) |=> !full_q);
    // R2
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !full_q && !chan_rst) |=> (full_q && data_q == $past(wr_data)));
    // R9
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && full_q && !chan_rst) |=> (ovr_q && $stable(data_q)));
endmodule

// File: rtl/txbuf_pend.sv
// Module: txbuf_pend
// Transmit interrupt pending bit. It is set on a drain edge or at end of
// frame while enabled, and cleared by a data write or by the clear command.
// Assumes: set events take priority over clear events in the same cycle.
module txbuf_pend
    import txbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_rst,
    input  logic tx_ie,
    input  logic xfer,
    input  logic crc_done,
    input  logic wr_stb,
    input  logic irq_clr,
    output logic irq_pend
);
    logic     pend_q;
    logic     set_ev;
    logic     clr_ev;
    pend_op_e op;

    // Choose the operation on the pending bit
    always_comb begin
        set_ev = tx_ie && (xfer || crc_done);
        clr_ev = wr_stb || irq_clr;
        op     = pend_pick(!rst_n || chan_rst, set_ev, clr_ev);
    end

    // Pending register
    always_ff @(posedge clk) begin
        case (op)
            PEND_RESET: pend_q <= 1'b0;
            PEND_SET:   pend_q <= 1'b1;
            PEND_CLEAR: pend_q <= 1'b0;
            default:    pend_q <= pend_q;
        endcase
    end

    assign irq_pend = pend_q;

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && xfer && !chan_rst) |=> pend_q);
    // R4
    pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(tx_ie));
    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_stb || irq_clr) && !(tx_ie && (xfer || crc_done))) |=> !pend_q);
endmodule

// File: rtl/txbuf_crcwatch.sv
// Module: txbuf_crcwatch
// Flags a CPU write landing while CRC bytes are in flight.
// Assumes: crc_busy covers the span from the first CRC byte entering the
// shift register until the last CRC bit leaves it.
module txbuf_crcwatch (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_rst,
    input  logic wr_stb,
    input  logic crc_busy,
    output logic late_wr
);
    logic late_q;

    // Sticky late-write flag
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst)       late_q <= 1'b0;
        else if (wr_stb && crc_busy)  late_q <= 1'b1;
    end

    assign late_wr = late_q;

    // R8
    late_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && crc_busy && !chan_rst) |=> late_q);
    // R8
    late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_q && !chan_rst) |=> late_q);
endmodule

// File: rtl/txbuf_irq_ctrl.sv
// Module: txbuf_irq_ctrl (top)
// One-byte transmit holding buffer with status, interrupt pending and
// request, and the late-write and write-to-full error flags.
// Assumes: all strobes are single-cycle and synchronous to clk.
module txbuf_irq_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              tx_ie,
    input  logic              mie,
    input  logic              ld_req,
    input  logic              crc_busy,
    input  logic              crc_done,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              buf_empty,
    output logic              irq_pend,
    output logic              irq_req,
    output logic              late_wr,
    output logic              ovr_err
);
    logic full;
    logic xfer;

    txbuf_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .wr_stb(wr_stb), .wr_data(wr_data), .ld_req(ld_req),
        .crc_done(crc_done), .full(full), .xfer(xfer),
        .data(ld_data), .ovr_err(ovr_err)
    );

    txbuf_pend u_pend (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .tx_ie(tx_ie),
        .xfer(xfer), .crc_done(crc_done), .wr_stb(wr_stb),
        .irq_clr(irq_clr), .irq_pend(irq_pend)
    );

    txbuf_crcwatch u_crc (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .wr_stb(wr_stb), .crc_busy(crc_busy), .late_wr(late_wr)
    );

    // Drive the status and request outputs
    always_comb begin
        buf_empty = !full;
        ld_valid  = xfer;
        irq_req   = irq_pend && mie;
    end

    // R1
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (buf_empty && !irq_pend && !late_wr && !ovr_err));
    // R7
    req_needs_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (mie && irq_pend));
    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_done && tx_ie && !wr_stb && !chan_rst) |=> (buf_empty && irq_pend));
endmodule

// File: tb/txbuf_irq_ctrl_bench.sv
module txbuf_irq_ctrl_bench;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n, chan_rst, wr_stb, irq_clr, tx_ie, mie, ld_req, crc_busy, crc_done;
    logic [DW-1:0] wr_data;
    logic ld_valid, buf_empty, irq_pend, irq_req, late_wr, ovr_err;
    logic [DW-1:0] ld_data;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    txbuf_irq_ctrl #(.DATA_W(DW)) u_txbuf_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .wr_stb(wr_stb),
        .wr_data(wr_data), .irq_clr(irq_clr), .tx_ie(tx_ie), .mie(mie),
        .ld_req(ld_req), .crc_busy(crc_busy), .crc_done(crc_done),
        .ld_valid(ld_valid), .ld_data(ld_data), .buf_empty(buf_empty),
        .irq_pend(irq_pend), .irq_req(irq_req), .late_wr(late_wr), .ovr_err(ovr_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock; land 1 ns after the edge and drop single-cycle strobes
    task automatic step();
        @(posedge clk);
        #1;
        wr_stb = 0; irq_clr = 0; ld_req = 0; crc_done = 0; chan_rst = 0;
    endtask

    task automatic write(input int d);
        wr_stb = 1; wr_data = DW'(d);
        step();
    endtask

    task automatic check_cleared(input string tag);
        check({tag, " buf_empty"}, buf_empty, 1);
        check({tag, " irq_pend"}, irq_pend, 0);
        check({tag, " late_wr"}, late_wr, 0);
        check({tag, " ovr_err"}, ovr_err, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chan_rst = 0; wr_stb = 0; wr_data = '0; irq_clr = 0;
        tx_ie = 0; mie = 0; ld_req = 0; crc_busy = 0; crc_done = 0;
        step(); step();
        rst_n = 1;
        #1;
        check_cleared("R1 hw reset");

        // Sweep every data value under every enable combination
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int d = 0; d < (1 << DW); d++) begin
                tx_ie = cfg[0]; mie = cfg[1];
                write(d);
                check("R2 empty after write", buf_empty, 0);
                check("R2 held data", ld_data, d);
                check("R6 write clears pend", irq_pend, 0);
                ld_req = 1;
                #1;
                check("R3 ld_valid", ld_valid, 1);
                check("R3 ld_data at transfer", ld_data, d);
                step();
                check("R3 R10 empty after transfer", buf_empty, 1);
                check("R4 pend on drain", irq_pend, cfg[0]);
                check("R7 irq_req", irq_req, cfg[0] & cfg[1]);
                irq_clr = 1;
                step();
                check("R6 clear command", irq_pend, 0);
            end
        end

        // R4: enabling interrupts while already empty does not set pending
        tx_ie = 0; mie = 1;
        step();
        tx_ie = 1;
        step(); step();
        check("R4 enable while empty", irq_pend, 0);
        ld_req = 1;
        #1;
        check("R3 no transfer when empty", ld_valid, 0);
        step();
        check("R4 empty ld_req no pend", irq_pend, 0);

        // R7: pending still visible with master enable off
        mie = 0;
        write(5); ld_req = 1; step();
        check("R7 pend with mie off", irq_pend, 1);
        check("R7 no request with mie off", irq_req, 0);
        mie = 1;
        #1;
        check("R7 request follows mie", irq_req, 1);

        // R6: set event beats clear command in the same cycle
        irq_clr = 1; step();
        write(9);
        irq_clr = 1; ld_req = 1; step();
        check("R6 set beats clear", irq_pend, 1);
        irq_clr = 1; step();

        // R9: write to full buffer is ignored and flagged
        write(3);
        write(12);
        check("R9 held byte kept", ld_data, 3);
        check("R9 ovr_err set", ovr_err, 1);
        step();
        check("R9 ovr_err sticky", ovr_err, 1);
        chan_rst = 1; step();
        check_cleared("R1 channel reset");

        // R5: end of frame sets pending and empty, even with a byte held
        tx_ie = 1;
        crc_done = 1; step();
        check("R5 pend at frame end", irq_pend, 1);
        check("R5 empty at frame end", buf_empty, 1);
        write(7);
        check("R5 pend cleared by write", irq_pend, 0);
        crc_done = 1; step();
        check("R5 held byte dropped", buf_empty, 1);
        check("R5 pend set again", irq_pend, 1);
        tx_ie = 0;
        irq_clr = 1; step();
        crc_done = 1; step();
        check("R5 no pend when disabled", irq_pend, 0);

        // R8: late write during CRC is sticky
        write(1);
        check("R8 normal write no flag", late_wr, 0);
        ld_req = 1; step();
        crc_busy = 1;
        write(2);
        crc_busy = 0;
        check("R8 late_wr set", late_wr, 1);
        step(); step();
        check("R8 late_wr sticky", late_wr, 1);
        rst_n = 0; step();
        rst_n = 1;
        #1;
        check_cleared("R1 hw reset again");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule